// File: doc/BRIEF.md
# Cascadable Synchronous BCD Digit Counter

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps 0, 1, 2, … 9 and then back to 0. The counter advances only when two count-enable inputs are both high. A synchronous clear returns it to zero, and a synchronous parallel load presets it to any value. Every state bit sits on the same clock, so all output bits change together on one rising edge.

A terminal-count carry goes high while the digit reads 9 and both enables are high. Several digits form a multi-digit decimal counter by feeding each digit's carry into both enable inputs of the next more significant digit. Every digit shares the clock. The carry is qualified by the enables, so a higher digit steps exactly once each time the chain below it rolls over.

A value from 10 to 15 can be loaded. From such a value, the next enabled count returns the digit to 0, so the digit cannot lock up outside the decimal range.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` becomes 0 after that edge.
- R2: When `clr` is high at a rising edge, `count` becomes 0, whatever `load`, `load_val` and the enables are doing.
- R3: When `load` is high and `clr` is low at a rising edge, `count` takes the 4-bit value on `load_val`, including values 10 to 15.
- R4: When `clr` and `load` are low, both enables are high and `count` is below 9, `count` increases by exactly one at the edge.
- R5: When `clr` and `load` are low, both enables are high and `count` is 9, `count` becomes 0 at the edge.
- R6: When `clr` and `load` are low and either enable is low, `count` keeps its value across the edge.
- R7: `carry` is a combinational output. It is high exactly when `count` equals 9 and both `en_a` and `en_b` are high.
- R8: When `clr` and `load` are low, both enables are high and `count` is 10 to 15, `count` becomes 0 at the edge.
- R9: When a second digit has both enables driven by the first digit's `carry`, the second digit advances once for each 9-to-0 wrap of the first digit, on the same edge as that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all digits of a chain |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear to 0; highest priority |
| load | input | 1 | Synchronous parallel load of `load_val` |
| load_val | input | 4 | Value to preset |
| en_a | input | 1 | First count enable |
| en_b | input | 1 | Second count enable |
| count | output | 4 | Current digit value |
| carry | output | 1 | Terminal-count carry, gated by both enables |

## Verification
A wrong next-state choice shows on `count` one edge after the offending cycle. The bench compares every cycle, so a wrong priority between clear, load and counting is caught in the first cycle where two controls collide. A carry that is wrong or not gated by the enables shows immediately on `carry`. In a two-digit chain, that fault also shows one edge later as a wrong upper digit. A digit stuck in the 10–15 range shows up as a mismatch after the first enabled edge following the out-of-range load.

// File: rtl/bcd_ctr_pkg.sv
// Shared types for the BCD digit counter.
// Assumes: consumers import the package; the action encoding is internal only.
package bcd_ctr_pkg;

    // Edge action chosen for the digit register.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_COUNT = 2'd3
    } ctr_action_e;

endpackage

// File: rtl/bcd_ctrl_decode.sv
// Priority decoder: turns the raw control inputs into one edge action.
// Assumes: clear outranks load, load outranks counting, and counting needs
// both enables.
module bcd_ctrl_decode
    import bcd_ctr_pkg::*;
(
    input  logic        clr,
    input  logic        load,
    input  logic        en_a,
    input  logic        en_b,
    output ctr_action_e action
);

    // Priority selection of the action for the next edge.
    always_comb begin
        if (clr)
            action = ACT_CLEAR;
        else if (load)
            action = ACT_LOAD;
        else if (en_a && en_b)
            action = ACT_COUNT;
        else
            action = ACT_HOLD;
    end

endmodule

// File: rtl/bcd_next_value.sv
// Next-value generator for one digit.
// Assumes: LAST_VAL is the final value of the sequence; any value at or
// above LAST_VAL wraps to zero when counting.
module bcd_next_value
    import bcd_ctr_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LAST_VAL = 9
) (
    input  ctr_action_e      action,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] nxt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_VAL);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    // Increment with wrap; out-of-range values fall back to zero.
    logic [CNT_W-1:0] stepped;
    always_comb begin
        stepped = (cur >= LAST) ? '0 : cur + ONE;
    end

    // Choose the value the register takes at the next edge.
    always_comb begin
        unique case (action)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = load_val;
            ACT_COUNT: nxt = stepped;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcd_tc_detect.sv
// Terminal-count detector producing the enable-gated carry.
// Assumes: the carry feeds both enables of the next digit on the same clock.
module bcd_tc_detect #(
    parameter int CNT_W    = 4,
    parameter int LAST_VAL = 9
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             en_a,
    input  logic             en_b,
    output logic             carry
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_VAL);

    // Carry only when at the final value and counting is enabled.
    always_comb begin
        carry = (cur == LAST) && en_a && en_b;
    end

endmodule

// File: rtl/bcd_digit_counter.sv
// One cascadable synchronous decimal digit.
// Assumes: one shared clock, a synchronous active-low reset, and chaining by
// wiring carry to both enables of the next digit.
module bcd_digit_counter
    import bcd_ctr_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LAST_VAL = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en_a,
    input  logic             en_b,
    output logic [CNT_W-1:0] count,
    output logic             carry
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_VAL);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    ctr_action_e      action;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cnt_q;

    bcd_ctrl_decode u_decode (
        .clr    (clr),
        .load   (load),
        .en_a   (en_a),
        .en_b   (en_b),
        .action (action)
    );

    bcd_next_value #(.CNT_W(CNT_W), .LAST_VAL(LAST_VAL)) u_next (
        .action   (action),
        .cur      (cnt_q),
        .load_val (load_val),
        .nxt      (nxt)
    );

    bcd_tc_detect #(.CNT_W(CNT_W), .LAST_VAL(LAST_VAL)) u_tc (
        .cur   (cnt_q),
        .en_a  (en_a),
        .en_b  (en_b),
        .carry (carry)
    );

    // Digit register: synchronous reset, otherwise takes the selected value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= nxt;
    end

    assign count = cnt_q;

    // R1: reset forces zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R2: clear wins over everything else.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    // R3: load presets the value.
    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load) |=> count == $past(load_val));

    // R4: enabled step below the final value.
    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && en_a && en_b && count < LAST)
        |=> count == $past(count) + ONE);

    // R5: wrap from the final value.
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && en_a && en_b && count == LAST) |=> count == '0);

    // R6: either enable low holds the value.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !(en_a && en_b)) |=> $stable(count));

    // R7: a carry without clear or load is followed by zero.
    assert_carry_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clr && !load) |=> count == '0);

    // R8: out-of-range values recover to zero.
    assert_range_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && en_a && en_b && count > LAST) |=> count == '0);

endmodule

// File: tb/bcd_digit_counter_test.sv
module bcd_digit_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr, load, en_a, en_b;
    logic [3:0] load_val;
    logic [3:0] count;
    logic       carry;
    logic       hi_clr, hi_load;
    logic [3:0] hi_load_val;
    logic [3:0] hi_count;
    logic       hi_carry;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_lo = 4'd0;
    logic [3:0] m_hi = 4'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_digit_counter uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(load_val),
        .en_a(en_a), .en_b(en_b), .count(count), .carry(carry)
    );

    // Upper digit: both enables come from the lower digit's carry.
    bcd_digit_counter uut_hi (
        .clk(clk), .rst_n(rst_n), .clr(hi_clr), .load(hi_load),
        .load_val(hi_load_val), .en_a(carry), .en_b(carry),
        .count(hi_count), .carry(hi_carry)
    );

    function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic c,
        input logic l, input logic [3:0] v, input logic ea, input logic eb);
        if (c) return 4'd0;
        if (l) return v;
        if (ea && eb) return (cur >= 4'd9) ? 4'd0 : cur + 4'd1;
        return cur;
    endfunction

    function automatic logic ref_carry(input logic [3:0] cur, input logic ea,
        input logic eb);
        return (cur == 4'd9) && ea && eb;
    endfunction

    function automatic string lo_tag(input logic [3:0] cur, input logic c,
        input logic l, input logic ea, input logic eb);
        if (c) return "R2";
        if (l) return "R3";
        if (!(ea && eb)) return "R6";
        if (cur < 4'd9) return "R4";
        if (cur == 4'd9) return "R5";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [3:0] act,
        input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check carries, clock, check counts.
    task automatic cycle(input logic c, input logic l, input logic [3:0] v,
        input logic ea, input logic eb, input logic hc, input logic hl,
        input logic [3:0] hv);
        logic exp_carry;
        string tag;
        clr = c; load = l; load_val = v; en_a = ea; en_b = eb;
        hi_clr = hc; hi_load = hl; hi_load_val = hv;
        #1;
        exp_carry = ref_carry(m_lo, ea, eb);
        check("R7", {3'b0, carry}, {3'b0, exp_carry});
        check("R7", {3'b0, hi_carry}, {3'b0, ref_carry(m_hi, exp_carry, exp_carry)});
        tag = lo_tag(m_lo, c, l, ea, eb);
        m_hi = ref_next(m_hi, hc, hl, hv, exp_carry, exp_carry);
        m_lo = ref_next(m_lo, c, l, v, ea, eb);
        @(posedge clk);
        @(negedge clk);
        check(tag, count, m_lo);
        check("R9", hi_count, m_hi);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4123));
        rst_n = 1'b0; clr = 1'b0; load = 1'b1; load_val = 4'd7;
        en_a = 1'b1; en_b = 1'b1; hi_clr = 1'b0; hi_load = 1'b1; hi_load_val = 4'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", count, 4'd0);
        check("R1", hi_count, 4'd0);
        rst_n = 1'b1;
        m_lo = 4'd0; m_hi = 4'd0;

        // Directed: load 7, count up through 9 and wrap (R3, R4, R5, R9).
        cycle(0, 1, 4'd7, 0, 0, 0, 0, 4'd0);
        for (int i = 0; i < 4; i++) cycle(0, 0, 4'd0, 1, 1, 0, 0, 4'd0);
        // Hold with only one enable (R6).
        cycle(0, 0, 4'd0, 1, 0, 0, 0, 4'd0);
        cycle(0, 0, 4'd0, 0, 1, 0, 0, 4'd0);
        // Out-of-range loads recover (R8).
        cycle(0, 1, 4'd12, 1, 1, 0, 0, 4'd0);
        cycle(0, 0, 4'd0, 1, 1, 0, 0, 4'd0);
        cycle(0, 1, 4'd15, 0, 0, 0, 0, 4'd0);
        cycle(0, 0, 4'd0, 0, 1, 0, 0, 4'd0);
        cycle(0, 0, 4'd0, 1, 1, 0, 0, 4'd0);
        // Clear beats load and count (R2).
        cycle(0, 1, 4'd9, 0, 0, 0, 1, 4'd9);
        cycle(1, 1, 4'd3, 1, 1, 0, 0, 4'd0);
        // Two-digit run: 0..99 and wrap of both digits (R9).
        cycle(1, 0, 4'd0, 0, 0, 1, 0, 4'd0);
        for (int i = 0; i < 105; i++) cycle(0, 0, 4'd0, 1, 1, 0, 0, 4'd0);

        // Constrained random mix.
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic c, l, ea, eb, hc, hl;
            logic [3:0] v, hv;
            c  = ($urandom_range(0, 19) == 0);
            l  = ($urandom_range(0, 9) == 0);
            v  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(10, 15))
                                             : 4'($urandom_range(0, 9));
            ea = ($urandom_range(0, 4) != 0);
            eb = ($urandom_range(0, 4) != 0);
            hc = ($urandom_range(0, 49) == 0);
            hl = ($urandom_range(0, 49) == 0);
            hv = 4'($urandom_range(0, 15));
            cycle(c, l, v, ea, eb, hc, hl, hv);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule